// File: doc/BRIEF.md
# Timestamp-Lease Coherence Controller

This block keeps a set of private L1 tag arrays coherent with one shared L2 bank. It does so without sending any invalidation or acknowledgement between them. All parties compare line timestamps against one global time value, which the surrounding system advances once per cycle. When a load misses in L1, the L2 grants a lease that ends at `global_time + lease_len`. The requesting L1 records that end time. The L2 keeps, for every line, the latest lease end it has handed out.

An L1 copy can be used only while its lease end is strictly later than the current global time. Once it is not, the next load is a miss, treated exactly like a cold miss. A store is written straight into the L2. It never waits for or contacts another L1: once the L2's recorded lease end is behind global time, no valid copy can remain. If some lease is still live, the store still completes at once under weak ordering. In that case it returns the L2 lease end, and the controller folds that value into `fence_wait_until`. A later fence stalls until global time has passed that value.

One request is accepted per cycle. Its result appears on the registered outputs in the following cycle. Data arrays, interconnect timing and lease prediction are not modelled.

Top module: `tslc_coherence_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `l1_hit`, `l2_resp_valid`, `l2_resp_timestamp` and `fence_wait_until` are all zero, and no L1 line is usable.
- R2: A load that misses in its L1 produces `l2_resp_valid`=1 and `l1_hit`=0 in the cycle after the request. The reported timestamp is the lease end `global_time + lease_len` when the line had no later lease recorded in L2.
- R3: On a load miss the L2 records, and reports, the larger of the lease end it already holds and the newly granted lease end. The requesting L1 records the newly granted end `global_time + lease_len`.
- R4: A load whose line is present in the selected L1 (set = `l1_req_addr[1:0]`, tag = the remaining upper address bits, core chosen by `l1_req_core`) gives `l1_hit`=1 and `l2_resp_valid`=0 in the next cycle, provided its stored lease end is strictly greater than `global_time`.
- R5: When the stored lease end equals or is below `global_time`, the load misses and is granted a new lease exactly as a cold miss is.
- R6: A store always goes to the L2: `l2_resp_valid`=1 in the next cycle, with the L2 lease end the line held before the store. The store leaves that L2 lease end unchanged.
- R7: A store sends nothing to other L1 arrays: another core's unexpired copy of the same line still hits after the store.
- R8: A store removes the storing core's own L1 copy of that line, so that core's next load of the line misses.
- R9: `fence_wait_until` equals the largest timestamp returned by any store since reset. It never decreases.
- R10: Each L1 is direct mapped. A load to the same set with a different tag misses and replaces the resident line. The replaced line then misses when it is loaded again.
- R11: A fill into one core's L1 does not make the line hit for a different core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_time | input | TS_W | Shared time value, advanced once per cycle by the system |
| lease_len | input | TS_W | Lease length granted on a load miss |
| l1_req_valid | input | 1 | A request is present this cycle |
| l1_req_core | input | CORE_W | Index of the requesting core's L1 |
| l1_req_addr | input | ADDR_W | Line address |
| l1_req_is_store | input | 1 | 1 = store, 0 = load |
| l1_hit | output | 1 | Previous cycle's load hit a live L1 lease |
| l2_resp_valid | output | 1 | Previous cycle's request was served by the L2 |
| l2_resp_timestamp | output | TS_W | Lease end returned by the L2 (granted end for loads, held end for stores) |
| fence_wait_until | output | TS_W | Global time a fence must pass before completing |

## Verification
The hardest situation to reach is a store that lands while another core still holds a live lease on the same line. The store must leave that copy usable, and it must also clear the storing core's own copy and raise the fence target. The stimulus builds this up step by step. A long lease is granted to one core. A second core then takes a shorter lease on the same line, which must not lower the L2 record. The store is issued before either lease ends, and loads from both cores follow. Expiry exactly at equality, and a tag conflict that evicts a still-live line, are reached by setting `global_time` explicitly on each request.

// File: rtl/tslc_pkg.sv
package tslc_pkg;

  // Request kind decoded from the request port
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2
  } tslc_op_e;

  localparam int TSLC_TS_W_DEF    = 16;
  localparam int TSLC_ADDR_W_DEF  = 6;
  localparam int TSLC_SETS_DEF    = 4;
  localparam int TSLC_CORES_DEF   = 2;

endpackage

// File: rtl/tslc_l1_tags.sv
module tslc_l1_tags
  import tslc_pkg::*;
#(
  parameter int ADDR_W = TSLC_ADDR_W_DEF,
  parameter int SETS   = TSLC_SETS_DEF,
  parameter int TS_W   = TSLC_TS_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  tslc_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TS_W-1:0]   gtime_i,
  input  logic [TS_W-1:0]   grant_i,
  output logic              hit_o
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             used_q  [SETS];
  logic [TAG_W-1:0] tag_q   [SETS];
  logic [TS_W-1:0]  lease_q [SETS];

  logic             used_d;
  logic [TAG_W-1:0] tag_d;
  logic [TS_W-1:0]  lease_d;
  logic             wr_en;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_match;

  assign idx       = addr_i[IDX_W-1:0];
  assign tag       = addr_i[ADDR_W-1:IDX_W];
  assign tag_match = used_q[idx] && (tag_q[idx] == tag);
  assign hit_o     = tag_match && (lease_q[idx] > gtime_i);

  // Next state for the addressed set
  always_comb begin
    wr_en   = 1'b0;
    used_d  = used_q[idx];
    tag_d   = tag_q[idx];
    lease_d = lease_q[idx];
    if (sel_i && op_i == OP_LOAD && !hit_o) begin
      wr_en   = 1'b1;
      used_d  = 1'b1;
      tag_d   = tag;
      lease_d = grant_i;
    end else if (sel_i && op_i == OP_STORE && tag_match) begin
      wr_en   = 1'b1;
      used_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        used_q[s]  <= 1'b0;
        tag_q[s]   <= '0;
        lease_q[s] <= '0;
      end
    end else if (wr_en) begin
      used_q[idx]  <= used_d;
      tag_q[idx]   <= tag_d;
      lease_q[idx] <= lease_d;
    end
  end

  // R8: a store that matched leaves the set unusable in the next cycle
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i && op_i == OP_STORE && tag_match |=> !used_q[$past(idx)]);

endmodule

// File: rtl/tslc_l2_bank.sv
module tslc_l2_bank
  import tslc_pkg::*;
#(
  parameter int ADDR_W = TSLC_ADDR_W_DEF,
  parameter int TS_W   = TSLC_TS_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  tslc_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TS_W-1:0]   grant_i,
  output logic [TS_W-1:0]   resp_ts_o
);

  localparam int LINES = 1 << ADDR_W;

  logic [TS_W-1:0] ts_q [LINES];
  logic [TS_W-1:0] cur_ts;
  logic [TS_W-1:0] merged_ts;
  logic            wr_en;

  assign cur_ts    = ts_q[addr_i];
  assign merged_ts = (cur_ts > grant_i) ? cur_ts : grant_i;

  always_comb begin
    resp_ts_o = cur_ts;
    wr_en     = 1'b0;
    if (req_i && op_i == OP_LOAD) begin
      resp_ts_o = merged_ts;
      wr_en     = (merged_ts != cur_ts);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) ts_q[l] <= '0;
    end else if (wr_en) begin
      ts_q[addr_i] <= merged_ts;
    end
  end

  // R6
  store_keeps_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && op_i == OP_STORE |=> ts_q[$past(addr_i)] == $past(cur_ts));

  // R3
  lease_never_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && op_i == OP_LOAD |=> ts_q[$past(addr_i)] >= $past(cur_ts));

endmodule

// File: rtl/tslc_fence.sv
module tslc_fence
  import tslc_pkg::*;
#(
  parameter int TS_W = TSLC_TS_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] wait_until_o
);

  logic [TS_W-1:0] wait_q;
  logic            en;

  assign en           = store_i && (ts_i > wait_q);
  assign wait_until_o = wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wait_q <= '0;
    else if (en) wait_q <= ts_i;
  end

  // R9
  fence_covers_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_i |=> wait_until_o >= $past(ts_i));

endmodule

// File: rtl/tslc_coherence_ctrl.sv
module tslc_coherence_ctrl
  import tslc_pkg::*;
#(
  parameter int NUM_CORES = TSLC_CORES_DEF,
  parameter int ADDR_W    = TSLC_ADDR_W_DEF,
  parameter int L1_SETS   = TSLC_SETS_DEF,
  parameter int TS_W      = TSLC_TS_W_DEF,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   global_time,
  input  logic [TS_W-1:0]   lease_len,
  input  logic              l1_req_valid,
  input  logic [CORE_W-1:0] l1_req_core,
  input  logic [ADDR_W-1:0] l1_req_addr,
  input  logic              l1_req_is_store,
  output logic              l1_hit,
  output logic              l2_resp_valid,
  output logic [TS_W-1:0]   l2_resp_timestamp,
  output logic [TS_W-1:0]   fence_wait_until
);

  tslc_op_e        req_op;
  logic [TS_W-1:0] grant_ts;
  logic [NUM_CORES-1:0] core_sel;
  logic [NUM_CORES-1:0] core_hit;
  logic            sel_hit;
  logic            load_hit;
  logic            l2_req;
  logic [TS_W-1:0] l2_ts;

  logic            hit_d, hit_q;
  logic            resp_v_d, resp_v_q;
  logic [TS_W-1:0] resp_ts_d, resp_ts_q;
  logic            resp_store_d, resp_store_q;
  logic            out_en;

  assign req_op   = !l1_req_valid ? OP_IDLE : (l1_req_is_store ? OP_STORE : OP_LOAD);
  assign grant_ts = global_time + lease_len;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign core_sel[c] = l1_req_valid && (l1_req_core == CORE_W'(c));
    tslc_l1_tags #(
      .ADDR_W (ADDR_W),
      .SETS   (L1_SETS),
      .TS_W   (TS_W)
    ) i_l1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (core_sel[c]),
      .op_i    (req_op),
      .addr_i  (l1_req_addr),
      .gtime_i (global_time),
      .grant_i (grant_ts),
      .hit_o   (core_hit[c])
    );
  end

  assign sel_hit  = |(core_sel & core_hit);
  assign load_hit = (req_op == OP_LOAD) && sel_hit;
  assign l2_req   = (req_op == OP_STORE) || ((req_op == OP_LOAD) && !sel_hit);

  tslc_l2_bank #(
    .ADDR_W (ADDR_W),
    .TS_W   (TS_W)
  ) i_l2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (l2_req),
    .op_i      (req_op),
    .addr_i    (l1_req_addr),
    .grant_i   (grant_ts),
    .resp_ts_o (l2_ts)
  );

  tslc_fence #(
    .TS_W (TS_W)
  ) i_fence (
    .clk          (clk),
    .rst_n        (rst_n),
    .store_i      (req_op == OP_STORE),
    .ts_i         (l2_ts),
    .wait_until_o (fence_wait_until)
  );

  // Output next state
  always_comb begin
    hit_d        = load_hit;
    resp_v_d     = l2_req;
    resp_store_d = (req_op == OP_STORE);
    resp_ts_d    = l2_req ? l2_ts : resp_ts_q;
    out_en       = l1_req_valid || hit_q || resp_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q        <= 1'b0;
      resp_v_q     <= 1'b0;
      resp_store_q <= 1'b0;
      resp_ts_q    <= '0;
    end else if (out_en) begin
      hit_q        <= hit_d;
      resp_v_q     <= resp_v_d;
      resp_store_q <= resp_store_d;
      resp_ts_q    <= resp_ts_d;
    end
  end

  assign l1_hit            = hit_q;
  assign l2_resp_valid     = resp_v_q;
  assign l2_resp_timestamp = resp_ts_q;

  // R2
  resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_resp_valid |-> $past(l1_req_valid));

  // R4
  hit_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_hit |-> $past(l1_req_valid && !l1_req_is_store));

  // R3
  grant_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_resp_valid && !resp_store_q |-> l2_resp_timestamp >= $past(global_time + lease_len));

  // R9
  fence_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_resp_valid && resp_store_q |-> fence_wait_until >= l2_resp_timestamp);

endmodule

// File: tb/test_tslc_coherence_ctrl.sv
module test_tslc_coherence_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W   = 16;
  localparam int ADDR_W = 6;

  logic              clk;
  logic              rst_n;
  logic [TS_W-1:0]   global_time;
  logic [TS_W-1:0]   lease_len;
  logic              l1_req_valid;
  logic [0:0]        l1_req_core;
  logic [ADDR_W-1:0] l1_req_addr;
  logic              l1_req_is_store;
  logic              l1_hit;
  logic              l2_resp_valid;
  logic [TS_W-1:0]   l2_resp_timestamp;
  logic [TS_W-1:0]   fence_wait_until;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  tslc_coherence_ctrl i_tslc_coherence_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .global_time       (global_time),
    .lease_len         (lease_len),
    .l1_req_valid      (l1_req_valid),
    .l1_req_core       (l1_req_core),
    .l1_req_addr       (l1_req_addr),
    .l1_req_is_store   (l1_req_is_store),
    .l1_hit            (l1_hit),
    .l2_resp_valid     (l2_resp_valid),
    .l2_resp_timestamp (l2_resp_timestamp),
    .fence_wait_until  (fence_wait_until)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One request; outputs sampled at the following falling edge
  task automatic issue(input int core, input int addr, input bit st,
                       input int gt, input int lease);
    @(negedge clk);
    l1_req_valid    = 1'b1;
    l1_req_core     = 1'(core);
    l1_req_addr     = ADDR_W'(addr);
    l1_req_is_store = st;
    global_time     = TS_W'(gt);
    lease_len       = TS_W'(lease);
    @(posedge clk);
    @(negedge clk);
    l1_req_valid    = 1'b0;
  endtask

  task automatic expect_miss(input string req, input int ts);
    check({req, " hit"}, int'(l1_hit), 0);
    check({req, " resp_valid"}, int'(l2_resp_valid), 1);
    check({req, " timestamp"}, int'(l2_resp_timestamp), ts);
  endtask

  task automatic expect_hit(input string req);
    check({req, " hit"}, int'(l1_hit), 1);
    check({req, " resp_valid"}, int'(l2_resp_valid), 0);
  endtask

  task automatic t_reset;
    check("R1 hit", int'(l1_hit), 0);
    check("R1 resp_valid", int'(l2_resp_valid), 0);
    check("R1 timestamp", int'(l2_resp_timestamp), 0);
    check("R1 fence", int'(fence_wait_until), 0);
    issue(0, 1, 0, 0, 4);           // no line usable after reset
    expect_miss("R1 first load", 4);
  endtask

  task automatic t_lease_basics;
    issue(0, 5, 0, 0, 10);
    expect_miss("R2 cold load", 10);
    issue(0, 5, 0, 9, 10);
    expect_hit("R4 live lease");
    issue(0, 5, 0, 10, 10);          // lease end equals time: expired
    expect_miss("R5 expired load", 20);
  endtask

  task automatic t_max_and_isolation;
    issue(1, 5, 0, 12, 3);           // core 1 never filled: miss; L2 keeps 20
    expect_miss("R11 other core / R3 max", 20);
    issue(1, 5, 0, 13, 3);           // core 1 holds its own end 15
    expect_hit("R3 L1 keeps own grant");
  endtask

  task automatic t_store_live;
    issue(0, 5, 1, 13, 3);
    expect_miss("R6 store live", 20);
    check("R9 fence raised", int'(fence_wait_until), 20);
    issue(1, 5, 0, 14, 3);
    expect_hit("R7 other copy survives store");
    issue(0, 5, 0, 14, 3);           // own copy dropped; L2 still 20
    expect_miss("R8 own copy cleared / R6 unchanged", 20);
  endtask

  task automatic t_store_expired;
    issue(0, 9, 0, 40, 10);
    expect_miss("R2 load line 9", 50);
    issue(1, 9, 1, 51, 10);
    expect_miss("R6 store after expiry", 50);
    check("R9 fence max", int'(fence_wait_until), 50);
    issue(1, 5, 1, 60, 10);
    expect_miss("R6 store old line", 20);
    check("R9 fence not lowered", int'(fence_wait_until), 50);
  endtask

  task automatic t_conflict;
    issue(0, 13, 0, 70, 10);
    expect_miss("R10 load 13", 80);
    issue(0, 13, 0, 71, 10);
    expect_hit("R10 13 resident");
    issue(0, 5, 0, 72, 10);          // same set 1, other tag
    expect_miss("R10 conflict load 5", 82);
    issue(0, 13, 0, 73, 10);
    expect_miss("R10 evicted 13", 83);
  endtask

  initial begin
    rst_n = 1'b0;
    global_time = '0;
    lease_len = '0;
    l1_req_valid = 1'b0;
    l1_req_core = '0;
    l1_req_addr = '0;
    l1_req_is_store = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lease_basics();
    t_max_and_isolation();
    t_store_live();
    t_store_expired();
    t_conflict();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule